// File: doc/BRIEF.md
# Paired Register Transfer Unit

This block executes one kind of coprocessor-move instruction: it copies two 32-bit values in a single step, either from two integer registers into a pair of adjacent single-precision floating-point registers, or from such a pair back into two integer registers. It holds a 16-entry integer register file and a 32-entry floating-point register file. It also holds the pattern matcher for both instruction encodings and the logic that spots register choices whose result would be undefined.

Each cycle the surrounding pipeline presents an instruction word with a valid strobe. With the word it gives an encoding select, the condition-check outcome and the floating-point enable. The register updates land on the next rising edge. Two one-cycle flags report a disabled-unit fault and an unpredictable register choice, and in both cases nothing is written. The neighbouring integer pipeline preloads integer registers through a load port, and both register files have a combinational read port.

Top module: `pmv_unit`

## Requirements
- R1: After reset every integer and floating-point register reads zero and both flags are low.
- R2: The word matches only if bit 22 is 1, bit 21 is 0, bits 11:8 are 1010, bits 7:6 are 00 and bit 4 is 1. With `alt_enc`=0, bits 31:28 must also differ from 1111 and bits 27:23 must be 11000. With `alt_enc`=1, bits 31:23 must be 111011000. A non-matching valid word writes nothing and raises no flag.
- R3: The integer index `t` is bits 15:12 and `t2` is bits 19:16. The float index `m` is bits 3:0 as its upper four bits, with bit 5 as its lowest bit. The partner float register is `m+1`.
- R4: With bit 20 = 0, the next edge writes F[m] from G[t] and F[m+1] from G[t2]. The integer registers are unchanged.
- R5: With bit 20 = 1, the next edge writes G[t] from F[m] and G[t2] from F[m+1]. `t` and `t2` need not be adjacent.
- R6: A matching word with `cond_pass` low writes nothing and raises no flag.
- R7: A matching, condition-passing word with `fp_en` low raises `undef_flag` in the following cycle and writes nothing.
- R8: With `fp_en` high, a matching, condition-passing word raises `unpred_flag` in the following cycle and writes nothing if any of these holds: `t`=15, `t2`=15, `m`=31, or bit 20 = 1 with `t`=`t2`. `undef_flag` takes priority over `unpred_flag`.
- R9: Each flag is high for exactly the one cycle after its instruction. The two flags are never high together.
- R10: With `gp_ld_en` high and `insn_valid` low, the next edge writes `gp_ld_data` into G[`gp_ld_idx`]. While `insn_valid` is high the load port is ignored.
- R11: `gp_rd_data` and `fp_rd_data` show the current contents of the entries selected by `gp_rd_idx` and `fp_rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| alt_enc | input | 1 | 0: conditional encoding, 1: alternate encoding |
| cond_pass | input | 1 | Condition check passed |
| fp_en | input | 1 | Floating-point unit enabled |
| gp_ld_en | input | 1 | Integer register preload strobe |
| gp_ld_idx | input | 4 | Preload target index |
| gp_ld_data | input | DATA_W | Preload value |
| gp_rd_idx | input | 4 | Integer read index |
| gp_rd_data | output | DATA_W | Integer read value |
| fp_rd_idx | input | 5 | Float read index |
| fp_rd_data | output | DATA_W | Float read value |
| undef_flag | output | 1 | Instruction refused because the unit is disabled |
| unpred_flag | output | 1 | Instruction dropped for an unpredictable register choice |

## Verification
The bench goes after the odd float indices and the top pair 30/31. A decoder that put the extra bit at the top, or took `m+1` from the wrong field, would scramble values across the float file. It tries every unpredictable trigger on its own, and also `t`=`t2` in the direction that is legal, where an over-eager detector would drop a valid move. It also checks that a word matching the wrong encoding is ignored, that the condition and enable gates leave both files untouched, and that a preload arriving with an instruction is dropped rather than merged.

// File: rtl/pmv_pkg.sv
package pmv_pkg;
    localparam int GPR_N    = 16;
    localparam int FPR_N    = 32;
    localparam int GP_IDX_W = $clog2(GPR_N);
    localparam int FP_IDX_W = $clog2(FPR_N);

    typedef struct packed {
        logic                match;
        logic                to_gp;
        logic [GP_IDX_W-1:0] t;
        logic [GP_IDX_W-1:0] t2;
        logic [FP_IDX_W-1:0] m;
        logic [FP_IDX_W-1:0] m_next;
        logic                unpred;
    } pmv_dec_t;

    typedef struct packed {
        logic undef;
        logic unpred;
    } pmv_flags_t;
endpackage

// File: rtl/pmv_decode.sv
module pmv_decode
    import pmv_pkg::*;
(
    input  logic [31:0] word,
    input  logic        alt_enc,
    output pmv_dec_t    dec
);
    logic shared_ok;
    logic head_ok;

    always_comb begin
        shared_ok = word[22] && !word[21] && (word[11:8] == 4'b1010)
                    && (word[7:6] == 2'b00) && word[4];
        if (alt_enc)
            head_ok = (word[31:23] == 9'b111011000);
        else
            head_ok = (word[31:28] != 4'hF) && (word[27:23] == 5'b11000);

        dec.match  = shared_ok && head_ok;
        dec.to_gp  = word[20];
        dec.t      = word[15:12];
        dec.t2     = word[19:16];
        dec.m      = {word[3:0], word[5]};
        dec.m_next = dec.m + FP_IDX_W'(1);
        dec.unpred = (dec.t == GP_IDX_W'(GPR_N - 1))
                  || (dec.t2 == GP_IDX_W'(GPR_N - 1))
                  || (dec.m == FP_IDX_W'(FPR_N - 1))
                  || (dec.to_gp && (dec.t == dec.t2));
    end
endmodule

// File: rtl/pmv_regfile.sv
module pmv_regfile #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int NRD     = 3,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_a,
    input  logic [IW-1:0]             wa_a,
    input  logic [WIDTH-1:0]          wd_a,
    input  logic                      we_b,
    input  logic [IW-1:0]             wa_b,
    input  logic [WIDTH-1:0]          wd_b,
    input  logic [NRD-1:0][IW-1:0]    ra,
    output logic [NRD-1:0][WIDTH-1:0] rd
);
    logic [WIDTH-1:0] mem_d [ENTRIES];
    logic [WIDTH-1:0] mem_q [ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (we_a) mem_d[wa_a] = wd_a;
        if (we_b) mem_d[wa_b] = wd_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = mem_q[ra[g]];
    end

    AST_ONE_WRITER_PER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_a && we_b && (wa_a == wa_b)));  // R8
endmodule

// File: rtl/pmv_unit.sv
module pmv_unit
    import pmv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [31:0]         insn_word,
    input  logic                alt_enc,
    input  logic                cond_pass,
    input  logic                fp_en,
    input  logic                gp_ld_en,
    input  logic [GP_IDX_W-1:0] gp_ld_idx,
    input  logic [DATA_W-1:0]   gp_ld_data,
    input  logic [GP_IDX_W-1:0] gp_rd_idx,
    output logic [DATA_W-1:0]   gp_rd_data,
    input  logic [FP_IDX_W-1:0] fp_rd_idx,
    output logic [DATA_W-1:0]   fp_rd_data,
    output logic                undef_flag,
    output logic                unpred_flag
);
    pmv_dec_t   dec;
    pmv_flags_t flags_d, flags_q;
    logic       exec_ok, move_ok, ld_ok;

    logic [2:0][GP_IDX_W-1:0] gp_ra;
    logic [2:0][DATA_W-1:0]   gp_rd;
    logic [2:0][FP_IDX_W-1:0] fp_ra;
    logic [2:0][DATA_W-1:0]   fp_rd;

    logic                gp_we_a, gp_we_b, fp_we;
    logic [GP_IDX_W-1:0] gp_wa_a;
    logic [DATA_W-1:0]   gp_wd_a;

    pmv_decode u_dec (
        .word    (insn_word),
        .alt_enc (alt_enc),
        .dec     (dec)
    );

    always_comb begin
        exec_ok = insn_valid && dec.match && cond_pass;
        move_ok = exec_ok && fp_en && !dec.unpred;
        ld_ok   = gp_ld_en && !insn_valid;

        gp_we_a = (move_ok && dec.to_gp) || ld_ok;
        gp_wa_a = ld_ok ? gp_ld_idx  : dec.t;
        gp_wd_a = ld_ok ? gp_ld_data : fp_rd[0];
        gp_we_b = move_ok && dec.to_gp;
        fp_we   = move_ok && !dec.to_gp;

        gp_ra = {gp_rd_idx, dec.t2, dec.t};
        fp_ra = {fp_rd_idx, dec.m_next, dec.m};

        flags_d.undef  = exec_ok && !fp_en;
        flags_d.unpred = exec_ok && fp_en && dec.unpred;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    pmv_regfile #(.ENTRIES(GPR_N), .WIDTH(DATA_W), .NRD(3)) u_gpr (
        .clk  (clk),
        .rst_n(rst_n),
        .we_a (gp_we_a),
        .wa_a (gp_wa_a),
        .wd_a (gp_wd_a),
        .we_b (gp_we_b),
        .wa_b (dec.t2),
        .wd_b (fp_rd[1]),
        .ra   (gp_ra),
        .rd   (gp_rd)
    );

    pmv_regfile #(.ENTRIES(FPR_N), .WIDTH(DATA_W), .NRD(3)) u_fpr (
        .clk  (clk),
        .rst_n(rst_n),
        .we_a (fp_we),
        .wa_a (dec.m),
        .wd_a (gp_rd[0]),
        .we_b (fp_we),
        .wa_b (dec.m_next),
        .wd_b (gp_rd[1]),
        .ra   (fp_ra),
        .rd   (fp_rd)
    );

    assign gp_rd_data  = gp_rd[2];
    assign fp_rd_data  = fp_rd[2];
    assign undef_flag  = flags_q.undef;
    assign unpred_flag = flags_q.unpred;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_flag, unpred_flag}));  // R9
    AST_COND_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !cond_pass) |=> (!undef_flag && !unpred_flag));  // R6
    AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !dec.match) |=> (!undef_flag && !unpred_flag));  // R2
    AST_TO_FP_KEEPS_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !dec.to_gp) |=>
        ((gp_rd_data == $past(gp_rd_data)) || (gp_rd_idx != $past(gp_rd_idx))));  // R4
    AST_DISABLED_KEEPS_FP: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !fp_en) |=>
        ((fp_rd_data == $past(fp_rd_data)) || (fp_rd_idx != $past(fp_rd_idx))));  // R7
endmodule

// File: tb/pmv_unit_bench.sv
module pmv_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        alt_enc = 1'b0;
    logic        cond_pass = 1'b1;
    logic        fp_en = 1'b1;
    logic        gp_ld_en = 1'b0;
    logic [3:0]  gp_ld_idx = '0;
    logic [31:0] gp_ld_data = '0;
    logic [3:0]  gp_rd_idx = '0;
    logic [31:0] gp_rd_data;
    logic [4:0]  fp_rd_idx = '0;
    logic [31:0] fp_rd_data;
    logic        undef_flag, unpred_flag;

    int n_vec = 0;
    int n_bad = 0;
    int rot = 0;
    bit done = 0;

    logic [31:0] rg [16];
    logic [31:0] rf [32];
    bit exp_undef = 0, exp_unpred = 0;

    always #(PERIOD/2) clk = ~clk;

    pmv_unit u_pmv_unit (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .alt_enc(alt_enc), .cond_pass(cond_pass), .fp_en(fp_en),
        .gp_ld_en(gp_ld_en), .gp_ld_idx(gp_ld_idx), .gp_ld_data(gp_ld_data),
        .gp_rd_idx(gp_rd_idx), .gp_rd_data(gp_rd_data),
        .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data),
        .undef_flag(undef_flag), .unpred_flag(unpred_flag)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit alt, input logic [3:0] cond, input bit dir,
                                       input int t, input int t2, input int m);
        logic [31:0] w;
        w = alt ? 32'hEC40_0A10 : ({cond, 28'h0}) | 32'h0C40_0A10;
        w = w | (32'(dir) << 20) | (32'(t2) << 16) | (32'(t) << 12)
              | 32'(m >> 1) | (32'(m & 1) << 5);
        return w;
    endfunction

    function automatic bit ref_match(input logic [31:0] w, input bit alt);
        bit common;
        common = ((w & 32'h0060_0FD0) == 32'h0040_0A10);
        if (alt) return common && ((w & 32'hFF80_0000) == 32'hEC00_0000);
        return common && ((w & 32'h0F80_0000) == 32'h0C00_0000) && (w[31:28] != 4'hF);
    endfunction

    task automatic model_step();
        int t, t2, m;
        bit to_gp, bad;
        logic [31:0] a, b;
        exp_undef = 0;
        exp_unpred = 0;
        if (insn_valid) begin
            if (ref_match(insn_word, alt_enc) && cond_pass) begin
                t = int'(insn_word[15:12]);
                t2 = int'(insn_word[19:16]);
                m = int'(insn_word[3:0]) * 2 + int'(insn_word[5]);
                to_gp = insn_word[20];
                bad = (t == 15) || (t2 == 15) || (m == 31) || (to_gp && t == t2);
                if (!fp_en) exp_undef = 1;
                else if (bad) exp_unpred = 1;
                else if (to_gp) begin
                    a = rf[m]; b = rf[m+1];
                    rg[t] = a; rg[t2] = b;
                end else begin
                    a = rg[t]; b = rg[t2];
                    rf[m] = a; rf[m+1] = b;
                end
            end
        end else if (gp_ld_en) begin
            rg[gp_ld_idx] = gp_ld_data;
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #1;
        check(tag, "undef_flag", 32'(undef_flag), 32'(exp_undef));
        check(tag, "unpred_flag", 32'(unpred_flag), 32'(exp_unpred));
        gp_rd_idx = 4'(rot % 16);
        fp_rd_idx = 5'(rot % 32);
        #1;
        check(tag, "gp read", gp_rd_data, rg[rot % 16]);
        check(tag, "fp read", fp_rd_data, rf[rot % 32]);
        rot++;
    endtask

    task automatic apply(input string tag, input bit v, input logic [31:0] w, input bit alt,
                         input bit cp, input bit fe, input bit le, input int li, input logic [31:0] ld);
        insn_valid = v; insn_word = w; alt_enc = alt; cond_pass = cp; fp_en = fe;
        gp_ld_en = le; gp_ld_idx = 4'(li); gp_ld_data = ld;
        tick(tag);
    endtask

    task automatic idle_sweep(input string tag);
        insn_valid = 0; gp_ld_en = 0;
        tick(tag);
        for (int i = 0; i < 16; i++) begin
            gp_rd_idx = 4'(i); #1;
            check(tag, "gp sweep", gp_rd_data, rg[i]);
        end
        for (int i = 0; i < 32; i++) begin
            fp_rd_idx = 5'(i); #1;
            check(tag, "fp sweep", fp_rd_data, rf[i]);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rg[i] = '0;
        for (int i = 0; i < 32; i++) rf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset contents and flags
        idle_sweep("R1");

        // R10: preload all integer registers
        for (int i = 0; i < 16; i++)
            apply("R10", 0, '0, 0, 1, 1, 1, i, 32'hC0DE_0000 + 32'(i) * 32'h0101_0011);
        // R10: preload alongside an instruction is ignored
        apply("R10", 1, 32'h0, 0, 1, 1, 1, 2, 32'hDEAD_BEEF);
        idle_sweep("R10");

        // R4 / R3: integer to float, both encodings, odd index, top pair
        apply("R4", 1, mk(0, 4'hE, 0, 1, 7, 4), 0, 1, 1, 0, 0, 0);
        apply("R3", 1, mk(1, 4'h0, 0, 2, 2, 9), 1, 1, 1, 0, 0, 0);
        apply("R4", 1, mk(0, 4'h3, 0, 5, 6, 30), 0, 1, 1, 0, 0, 0);
        apply("R3", 1, mk(0, 4'h1, 0, 11, 13, 17), 0, 1, 1, 0, 0, 0);
        idle_sweep("R4");

        // R5: float to integer with non-adjacent targets
        apply("R5", 1, mk(0, 4'h0, 1, 3, 10, 9), 0, 1, 1, 0, 0, 0);
        apply("R5", 1, mk(1, 4'h0, 1, 12, 0, 30), 1, 1, 1, 0, 0, 0);
        apply("R5", 1, mk(0, 4'hA, 1, 8, 4, 17), 0, 1, 1, 0, 0, 0);
        idle_sweep("R5");

        // R6: condition failed
        apply("R6", 1, mk(0, 4'hE, 0, 8, 9, 0), 0, 0, 1, 0, 0, 0);
        apply("R6", 1, mk(1, 4'h0, 1, 8, 9, 4), 1, 0, 1, 0, 0, 0);
        // R7: unit disabled
        apply("R7", 1, mk(0, 4'hE, 1, 4, 5, 4), 0, 1, 0, 0, 0, 0);
        apply("R9", 0, '0, 0, 1, 1, 0, 0, 0);
        apply("R7", 1, mk(0, 4'hE, 0, 4, 5, 20), 0, 1, 0, 0, 0, 0);
        // R8: disabled wins over unpredictable
        apply("R8", 1, mk(0, 4'hE, 0, 15, 5, 4), 0, 1, 0, 0, 0, 0);
        idle_sweep("R7");

        // R8: each unpredictable trigger
        apply("R8", 1, mk(0, 4'hE, 0, 15, 5, 2), 0, 1, 1, 0, 0, 0);
        apply("R8", 1, mk(0, 4'hE, 1, 5, 15, 2), 0, 1, 1, 0, 0, 0);
        apply("R8", 1, mk(1, 4'h0, 0, 1, 2, 31), 1, 1, 1, 0, 0, 0);
        apply("R8", 1, mk(0, 4'hE, 1, 6, 6, 9), 0, 1, 1, 0, 0, 0);
        // R8: equal indices toward float is legal
        apply("R8", 1, mk(0, 4'hE, 0, 6, 6, 12), 0, 1, 1, 0, 0, 0);
        idle_sweep("R8");

        // R2: near-miss words
        apply("R2", 1, mk(0, 4'hF, 0, 1, 2, 3), 0, 1, 1, 0, 0, 0);
        apply("R2", 1, mk(0, 4'h0, 0, 1, 2, 3), 1, 1, 1, 0, 0, 0);
        apply("R2", 1, mk(0, 4'hE, 0, 1, 2, 3) | 32'h0020_0000, 0, 1, 1, 0, 0, 0);
        apply("R2", 1, mk(0, 4'hE, 0, 1, 2, 3) | 32'h0000_0100, 0, 1, 1, 0, 0, 0);
        apply("R2", 1, mk(1, 4'h0, 1, 1, 2, 3) & ~32'h0000_0010, 1, 1, 1, 0, 0, 0);
        apply("R2", 1, mk(1, 4'h0, 1, 1, 2, 3) & ~32'h0040_0000, 1, 1, 1, 0, 0, 0);
        idle_sweep("R2");

        // R9: mixed random traffic against the model
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            bit alt;
            alt = 1'($urandom % 2);
            w = mk(alt, 4'($urandom % 16), 1'($urandom % 2), int'($urandom % 16),
                   int'($urandom % 16), int'($urandom % 32));
            if ($urandom % 8 == 0) w = w ^ (32'h1 << ($urandom % 32));
            if ($urandom % 8 == 0) alt = ~alt;
            apply("R9", 1'($urandom % 4 != 0), w, alt, 1'($urandom % 10 != 0),
                  1'($urandom % 10 != 0), 1'($urandom % 3 == 0), int'($urandom % 16), $urandom);
        end
        idle_sweep("R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule